// File: doc/BRIEF.md
# Cell-Level Utopia Transmit Master

This block is the transmit side of a single-PHY Utopia master that works on whole cells. It takes cells from a local cell buffer and sends them over a 16-bit transmit bus to a slave device. The local side gives a "cell ready" flag and presents the current buffer word at a read port. Each pulse of the read strobe moves that port on to the next word. Toward the slave, the block drives the data word, a parity bit, a start-of-cell marker and an active-low enable. It watches the slave's cell-available flag.

A strap sets the cell length in bytes. Its lowest bit is ignored, and the value is held in the 16 to 128 byte range. Once a cell has started, its words go out on consecutive clocks with no pause. At the last word the block decides whether a further cell follows at once or whether the enable is released. It looks at the slave flag and the buffer flag on that clock. All outputs are registered on the rising clock edge.

Top module: `utx_cell_master`

## Requirements
- R1: A cell starts only on a clock edge at which both `slave_clav_i` and `cell_rdy_i` are high. While the block is idle and either flag is low, `tx_enb_no` stays high and `rd_o` stays low.
- R2: `tx_enb_no` is low exactly while a valid word is on `tx_data_o`. `tx_soc_o` is high for one clock, together with the first word of each cell, and at no other time.
- R3: Once a cell has started, all of its words are sent on consecutive clocks in buffer order. There is one `rd_o` pulse per word, and changes on `slave_clav_i` or `cell_rdy_i` during the cell have no effect.
- R4: If both flags are high on the clock of a cell's last word, the next cell's first word, with `tx_soc_o` high, appears on the very next clock. `tx_enb_no` stays low in between.
- R5: If either flag is low on the clock of the last word, `tx_enb_no` goes high on the next clock and no further word is read.
- R6: Words per cell equal `cell_size_i[7:1]`, so bit 0 is ignored. Values below 16 bytes count as 16 bytes (8 words), and values above 128 bytes count as 128 bytes (64 words).
- R7: When `par_en_i` is high, `tx_prty_o` makes the 17 bits {data, parity} carry odd parity. When it is low, `tx_prty_o` is 0.
- R8: Under reset, `tx_enb_no` is 1 and `tx_soc_o`, `tx_data_o` and `tx_prty_o` are 0. The first word of a cell appears on the outputs one clock after the edge that accepts the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_size_i | input | 8 | Cell length strap in bytes (bit 0 ignored) |
| par_en_i | input | 1 | Parity generation enable strap |
| slave_clav_i | input | 1 | Slave can accept a whole cell |
| cell_rdy_i | input | 1 | Local buffer holds a complete cell |
| rd_o | output | 1 | Read strobe: the current buffer word is consumed |
| rd_data_i | input | 16 | Current buffer word |
| tx_data_o | output | 16 | Transmit data word |
| tx_prty_o | output | 1 | Transmit parity |
| tx_soc_o | output | 1 | Start of cell |
| tx_enb_no | output | 1 | Transmit enable, active low |

## Verification
Stimulus changes just after a falling edge. The first word of a cell is therefore expected at the next falling edge, one register stage after the accepting rising edge. The bench checks that latency against the cycle stamp of the captured word. After that, the n-th word of a train must carry the stamp of the first word plus n. Start-of-cell must fall on every multiple of the word count. The enable release or back-to-back decision is due one clock after the last word. Each scenario therefore waits the word count plus a margin before it checks the enable level and the number of reads. Flag changes are made only after the first word of the last cell has been seen, so the decision clock always sees the intended values.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned SIZE_W    = 8;
  localparam int unsigned MIN_BYTES = 16;
  localparam int unsigned MAX_BYTES = 128;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/utx_len.sv
module utx_len #(
  parameter int unsigned SIZE_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MIN_BYTES = 16,
  parameter int unsigned MAX_BYTES = 128,
  parameter int unsigned IDX_W     = 6
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [IDX_W-1:0]  last_idx_o
);
  localparam int unsigned BPW     = DATA_W / 8;
  localparam int unsigned SHIFT   = $clog2(BPW);
  localparam int unsigned MIN_WDS = MIN_BYTES / BPW;
  localparam int unsigned MAX_WDS = MAX_BYTES / BPW;

  logic [SIZE_W-1:0] words_raw;
  logic [SIZE_W-1:0] words;

  assign words_raw = size_i >> SHIFT;

  always_comb begin
    if (words_raw < SIZE_W'(MIN_WDS))      words = SIZE_W'(MIN_WDS);
    else if (words_raw > SIZE_W'(MAX_WDS)) words = SIZE_W'(MAX_WDS);
    else                                   words = words_raw;
  end

  assign last_idx_o = IDX_W'(words - SIZE_W'(1));
endmodule

// File: rtl/utx_ctr.sv
module utx_ctr #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] last_idx_i,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + IDX_W'(1);
  end

  assign last_o = (idx_q == last_idx_i);
endmodule

// File: rtl/utx_par.sv
module utx_par #(
  parameter int unsigned W   = 16,
  parameter bit          ODD = 1'b1
) (
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic         par_o
);
  assign par_o = en_i & ((^data_i) ^ ODD);
endmodule

// File: rtl/utx_cell_master.sv
module utx_cell_master #(
  parameter int unsigned DATA_W    = utx_pkg::DATA_W,
  parameter int unsigned SIZE_W    = utx_pkg::SIZE_W,
  parameter int unsigned MIN_BYTES = utx_pkg::MIN_BYTES,
  parameter int unsigned MAX_BYTES = utx_pkg::MAX_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] cell_size_i,
  input  logic              par_en_i,
  input  logic              slave_clav_i,
  input  logic              cell_rdy_i,
  output logic              rd_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_prty_o,
  output logic              tx_soc_o,
  output logic              tx_enb_no
);
  import utx_pkg::*;

  localparam int unsigned MAX_WDS = MAX_BYTES / (DATA_W / 8);
  localparam int unsigned IDX_W   = (MAX_WDS > 1) ? $clog2(MAX_WDS) : 1;

  tx_state_e        state_q;
  logic [IDX_W-1:0] last_idx;
  logic             ctr_last;
  logic             last_word;
  logic             take_new;
  logic             take_next;
  logic             par_nxt;

  logic [DATA_W-1:0] data_q;
  logic              prty_q, soc_q, enb_nq;

  utx_len #(
    .SIZE_W(SIZE_W), .DATA_W(DATA_W), .MIN_BYTES(MIN_BYTES),
    .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)
  ) u_len (
    .size_i    (cell_size_i),
    .last_idx_o(last_idx)
  );

  utx_ctr #(.IDX_W(IDX_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (take_new),
    .step_i    (take_next),
    .last_idx_i(last_idx),
    .last_o    (ctr_last)
  );

  utx_par #(.W(DATA_W), .ODD(1'b1)) u_par (
    .data_i(rd_data_i),
    .en_i  (par_en_i),
    .par_o (par_nxt)
  );

  assign last_word = (state_q == ST_SEND) && ctr_last;
  // new cell: from idle or directly after the last word
  assign take_new  = ((state_q == ST_IDLE) || last_word) && cell_rdy_i && slave_clav_i;
  assign take_next = (state_q == ST_SEND) && !ctr_last;
  assign rd_o      = take_new || take_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      prty_q  <= 1'b0;
      soc_q   <= 1'b0;
      enb_nq  <= 1'b1;
    end else begin
      state_q <= rd_o ? ST_SEND : ST_IDLE;
      soc_q   <= take_new;
      enb_nq  <= !rd_o;
      if (rd_o) begin
        data_q <= rd_data_i;
        prty_q <= par_nxt;
      end else begin
        data_q <= '0;
        prty_q <= 1'b0;
      end
    end
  end

  assign tx_data_o = data_q;
  assign tx_prty_o = prty_q;
  assign tx_soc_o  = soc_q;
  assign tx_enb_no = enb_nq;
endmodule

// File: rtl/utx_cell_master_chk.sv
module utx_cell_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  cell_size_i,
  input logic        par_en_i,
  input logic        slave_clav_i,
  input logic        cell_rdy_i,
  input logic        rd_o,
  input logic [15:0] tx_data_o,
  input logic        tx_prty_o,
  input logic        tx_soc_o,
  input logic        tx_enb_no
);
  logic [7:0] wds_raw, wds;
  logic [5:0] lim, pos_q, pos;

  assign wds_raw = cell_size_i >> 1;
  assign wds = (wds_raw < 8'd8) ? 8'd8 : (wds_raw > 8'd64) ? 8'd64 : wds_raw;
  assign lim = 6'(wds - 8'd1);
  assign pos = tx_soc_o ? 6'd0 : pos_q + 6'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pos_q <= '0;
    else if (!tx_enb_no) pos_q <= pos;
  end

  assert_start_adv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_enb_no) |-> $past(slave_clav_i && cell_rdy_i));

  assert_soc_in_enb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_soc_o |-> !tx_enb_no);

  assert_no_pause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_enb_no && pos != lim) |=> (!tx_enb_no && !tx_soc_o));

  assert_read_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !tx_enb_no);

  assert_cell_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_enb_no && pos == lim) |=> (tx_enb_no || tx_soc_o));

  assert_par_odd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_enb_no && $past(par_en_i)) |-> (tx_prty_o == ~^tx_data_o));

  assert_par_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_enb_no && !$past(par_en_i)) |-> !tx_prty_o);
endmodule

bind utx_cell_master utx_cell_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cell_size_i (cell_size_i),
  .par_en_i    (par_en_i),
  .slave_clav_i(slave_clav_i),
  .cell_rdy_i  (cell_rdy_i),
  .rd_o        (rd_o),
  .tx_data_o   (tx_data_o),
  .tx_prty_o   (tx_prty_o),
  .tx_soc_o    (tx_soc_o),
  .tx_enb_no   (tx_enb_no)
);

// File: tb/utx_cell_master_bench.sv
module utx_cell_master_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [7:0]  cell_size;
  logic        par_en, clav, rdy;
  logic        rd;
  logic [15:0] rd_data;
  logic [15:0] tx_data;
  logic        tx_prty, tx_soc, tx_enb_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  utx_cell_master u_utx_cell_master (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cell_size_i (cell_size),
    .par_en_i    (par_en),
    .slave_clav_i(clav),
    .cell_rdy_i  (rdy),
    .rd_o        (rd),
    .rd_data_i   (rd_data),
    .tx_data_o   (tx_data),
    .tx_prty_o   (tx_prty),
    .tx_soc_o    (tx_soc),
    .tx_enb_no   (tx_enb_n)
  );

  // local buffer model
  int rd_ptr;
  function automatic logic [15:0] pat(input int i);
    return 16'((i * 965) ^ 32'h9A17);
  endfunction
  assign rd_data = pat(rd_ptr);
  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) rd_ptr <= 0;
    else if (rd) rd_ptr <= rd_ptr + 1;

  // bus capture, sampled at falling edge
  int cyc = 0;
  int cap_n = 0;
  logic [15:0] cap_d [0:1023];
  bit cap_s [0:1023];
  bit cap_p [0:1023];
  int cap_c [0:1023];
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_ni === 1'b1 && tx_enb_n === 1'b0 && cap_n < 1024) begin
      cap_d[cap_n] = tx_data;
      cap_s[cap_n] = tx_soc;
      cap_p[cap_n] = tx_prty;
      cap_c[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; cell_size = 8'd16; par_en = 1'b1; clav = 1'b0; rdy = 1'b0;
    tick(3);
    chk(tx_enb_n == 1'b1, "R8 reset enable", tx_enb_n, 1);
    chk(tx_soc == 1'b0 && tx_prty == 1'b0, "R8 reset soc/parity", {tx_soc, tx_prty}, 0);
    chk(tx_data == 16'h0, "R8 reset data", tx_data, 0);
    chk(rd == 1'b0, "R8 reset read", rd, 0);
    rst_ni = 1'b1;
    tick(2);
  endtask

  task automatic t_no_start();
    int b = cap_n;
    int p = rd_ptr;
    rdy = 1'b1; clav = 1'b0;
    tick(12);
    chk(cap_n == b && rd_ptr == p, "R1 no start without slave flag", cap_n - b, 0);
    rdy = 1'b0; clav = 1'b1;
    tick(12);
    chk(cap_n == b && rd_ptr == p, "R1 no start without ready cell", rd_ptr - p, 0);
    clav = 1'b0;
    tick(2);
  endtask

  task automatic xfer(input int size, input int ncells, input bit par,
                      input bit drop_rdy, input string tag);
    int w, b, p, c0, n, guard;
    bit bd, bs, bc, bp;
    w = size >> 1;
    if (w < 8) w = 8;
    if (w > 64) w = 64;
    b = cap_n; p = rd_ptr;
    cell_size = 8'(size); par_en = par;
    rdy = 1'b1; clav = 1'b1;
    c0 = cyc;
    guard = 0;
    while (cap_n - b < w * (ncells - 1) + 1 && guard < 1000) begin
      tick(1);
      guard++;
    end
    if (drop_rdy) rdy = 1'b0; else clav = 1'b0;
    tick(w + 4);
    chk(tx_enb_n == 1'b1, {tag, " R5 enable released after last cell"}, tx_enb_n, 1);
    rdy = 1'b0; clav = 1'b0;
    n = cap_n - b;
    chk(n == w * ncells, {tag, " R6 word count"}, n, w * ncells);
    chk(rd_ptr - p == w * ncells, {tag, " R3 one read per word"}, rd_ptr - p, w * ncells);
    chk(cap_c[b] == c0 + 1, {tag, " R8 first word latency"}, cap_c[b] - c0, 1);
    bd = 0; bs = 0; bc = 0; bp = 0;
    for (int i = 0; i < n && i < w * ncells; i++) begin
      if (cap_d[b+i] != pat(p + i)) bd = 1;
      if (cap_s[b+i] != ((i % w) == 0)) bs = 1;
      if (cap_c[b+i] != cap_c[b] + i) bc = 1;
      if (cap_p[b+i] != (par ? ~^cap_d[b+i] : 1'b0)) bp = 1;
    end
    chk(!bd, {tag, " R3 words in buffer order"}, bd, 0);
    chk(!bs, {tag, " R2 R4 start-of-cell placement"}, bs, 0);
    chk(!bc, {tag, " R3 R4 consecutive clocks"}, bc, 0);
    chk(!bp, {tag, " R7 parity"}, bp, 0);
    tick(2);
  endtask

  initial begin
    t_reset();
    t_no_start();
    xfer(16, 1, 1'b1, 1'b0, "R5 single min cell");
    xfer(20, 3, 1'b1, 1'b0, "R4 back-to-back");
    xfer(24, 1, 1'b0, 1'b0, "R7 parity off");
    xfer(33, 1, 1'b1, 1'b0, "R6 odd strap");
    xfer(128, 2, 1'b1, 1'b0, "R6 max size");
    xfer(8, 1, 1'b1, 1'b0, "R6 clamp low");
    xfer(200, 1, 1'b0, 1'b0, "R6 clamp high");
    xfer(18, 2, 1'b1, 1'b1, "R5 buffer empty at last word");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule